// File: doc/BRIEF.md
# Tiled-Range Fence Register Bank

This block holds a parameterised set of fence descriptors, each of which marks a page-aligned span of linear address space as laid out in X or Y tiles with a given row pitch. A host programs each descriptor as a pair of 32-bit words through a plain register strobe interface and can read every word back. A lookup port accepts a linear address and, one clock later, reports whether any armed descriptor covers it, which one, its tiling kind and its row pitch in bytes.

A descriptor keeps its pitch as a count of 128-byte units minus one and keeps the address of its final 4 KiB page instead of a length. Because a descriptor is rewritten in two separate word writes, the bank disarms a descriptor whenever its upper word is written. A half-finished update therefore never takes part in matching, even if the host skips the zero write that a careful update sequence starts with. The bank only decides whether an address lies in a range. It does not convert addresses into tiled order, and it does not arbitrate between requesters.

Top module: `fence_bank`

## Requirements
- R1: A synchronous active-high reset clears every descriptor word to zero, so all read-backs return zero and no lookup hits afterwards.
- R2: The register address is {entry index, half}. Half 0 selects the low word and half 1 selects the high word. A read strobe returns the addressed word on `reg_rd_data` one cycle later, and the value holds until the next read.
- R3: Low-word layout: bit 0 is the armed (valid) flag, bit 1 is the tiling flag (0 = X, 1 = Y), bits [11:2] are the pitch field, and bits [31:12] are the start page. The word reads back exactly as written.
- R4: Bits [31:12] of the high word are the last page of the range. Bits [11:0] are not stored and read back as zero.
- R5: A write to the high word clears the armed flag of that entry in the same cycle. The entry does not match again until its low word is written with bit 0 set.
- R6: A lookup hits entry i when i is armed and start ≤ address ≤ last page + 4095. The result is registered and appears one cycle after `lk_req`.
- R7: On a hit, `lk_pitch` equals (pitch field + 1) × 128 and `lk_ytile` equals the tiling flag of the winning entry.
- R8: When several armed entries cover the address, the lowest index wins and `lk_overlap` is 1. It is 0 when exactly one entry covers the address.
- R9: When nothing matches, or when `lk_req` is low, `lk_hit`, `lk_index`, `lk_ytile`, `lk_pitch` and `lk_overlap` are all zero.
- R10: An unarmed entry never matches, even when its stored range covers the address. An all-zero entry covers page 0, and it must still not match.
- R11: Every entry index from 0 to ENTRIES−1 (ENTRIES = 8, 16 or 32) can be written, read back and matched, including the highest one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wr_addr | input | IDX_W+1 | Write address {index, half} |
| reg_wr_data | input | 32 | Write data |
| reg_rd_en | input | 1 | Register read strobe |
| reg_rd_addr | input | IDX_W+1 | Read address {index, half} |
| reg_rd_data | output | 32 | Registered read data |
| lk_req | input | 1 | Lookup request |
| lk_addr | input | 32 | Linear address to look up |
| lk_hit | output | 1 | An armed entry covers the address |
| lk_index | output | IDX_W | Index of the winning entry |
| lk_ytile | output | 1 | Winning entry is Y-tiled |
| lk_pitch | output | PITCH_W+8 | Row pitch in bytes |
| lk_overlap | output | 1 | More than one armed entry covered the address |

## Verification
A stored word that has gone wrong shows up on the first read-back of that word, two clock edges after the read strobe. A wrong armed flag shows up on the first lookup inside that entry's range: the result is a hit that should be a miss, or the reverse. A fault in the range comparison or the priority choice shows up one cycle after a lookup at the exact first and last byte of a range, or inside the overlap of two ranges, as a wrong index or overlap flag. A pitch field that is decoded with the wrong bias shows up on the pitch output as an error of exactly 128 bytes.

// File: rtl/fence_pkg.sv
package fence_pkg;
  localparam int DATA_W     = 32;
  localparam int PAGE_SHIFT = 12;
  localparam int PITCH_LSB  = 2;
  localparam int UNIT_SHIFT = 7;

  function automatic logic word_armed(input logic [DATA_W-1:0] w);
    return w[0];
  endfunction

  function automatic logic word_ytile(input logic [DATA_W-1:0] w);
    return w[1];
  endfunction
endpackage

// File: rtl/fence_entry.sv
module fence_entry
  import fence_pkg::*;
#(
  parameter int PAGE_W = DATA_W - PAGE_SHIFT
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_lo,
  input  logic              wr_hi,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [PAGE_W-1:0] lk_page,
  output logic [DATA_W-1:0] lo_q,
  output logic [DATA_W-1:0] hi_q,
  output logic              match
);
  logic [DATA_W-1:0] lo_r;
  logic [PAGE_W-1:0] last_r;

  always_ff @(posedge clk) begin
    if (rst) begin
      lo_r   <= '0;
      last_r <= '0;
    end else begin
      if (wr_lo) lo_r <= wr_data;
      if (wr_hi) begin
        last_r   <= wr_data[DATA_W-1:PAGE_SHIFT];
        lo_r[0]  <= 1'b0;
      end
    end
  end

  logic [PAGE_W-1:0] start_page;
  assign start_page = lo_r[DATA_W-1:PAGE_SHIFT];

  always_comb begin
    match = word_armed(lo_r) && (lk_page >= start_page) && (lk_page <= last_r);
  end

  assign lo_q = lo_r;
  assign hi_q = {last_r, {PAGE_SHIFT{1'b0}}};

  AST_HIGH_WRITE_DISARMS: assert property (@(posedge clk) disable iff (rst)
    (wr_hi && !wr_lo) |=> !match); // R5
endmodule

// File: rtl/fence_prio.sv
module fence_prio #(
  parameter int N     = 32,
  parameter int IDX_W = $clog2(N)
) (
  input  logic [N-1:0]     match,
  output logic             found,
  output logic [IDX_W-1:0] idx,
  output logic             multi
);
  always_comb begin
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (match[i]) idx = IDX_W'(i);
    end
  end

  assign found = |match;
  assign multi = |(match & (match - N'(1)));
endmodule

// File: rtl/fence_bank.sv
module fence_bank
  import fence_pkg::*;
#(
  parameter int ENTRIES = 32,
  parameter int PITCH_W = 10,
  parameter int IDX_W   = $clog2(ENTRIES)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 reg_wr_en,
  input  logic [IDX_W:0]       reg_wr_addr,
  input  logic [31:0]          reg_wr_data,
  input  logic                 reg_rd_en,
  input  logic [IDX_W:0]       reg_rd_addr,
  output logic [31:0]          reg_rd_data,
  input  logic                 lk_req,
  input  logic [31:0]          lk_addr,
  output logic                 lk_hit,
  output logic [IDX_W-1:0]     lk_index,
  output logic                 lk_ytile,
  output logic [PITCH_W+7:0]   lk_pitch,
  output logic                 lk_overlap
);
  localparam int PAGE_W = DATA_W - PAGE_SHIFT;
  localparam int PO_W   = PITCH_W + UNIT_SHIFT + 1;

  logic [DATA_W-1:0]  lo_all [ENTRIES];
  logic [DATA_W-1:0]  hi_all [ENTRIES];
  logic [ENTRIES-1:0] match_vec;
  logic [PAGE_W-1:0]  lk_page;

  assign lk_page = lk_addr[DATA_W-1:PAGE_SHIFT];

  for (genvar g = 0; g < ENTRIES; g++) begin : g_entry
    logic sel;
    assign sel = reg_wr_en && (reg_wr_addr[IDX_W:1] == IDX_W'(g));
    fence_entry #(.PAGE_W(PAGE_W)) u_entry (
      .clk     (clk),
      .rst     (rst),
      .wr_lo   (sel && !reg_wr_addr[0]),
      .wr_hi   (sel &&  reg_wr_addr[0]),
      .wr_data (reg_wr_data),
      .lk_page (lk_page),
      .lo_q    (lo_all[g]),
      .hi_q    (hi_all[g]),
      .match   (match_vec[g])
    );
  end

  logic             win_found;
  logic [IDX_W-1:0] win_idx;
  logic             win_multi;

  fence_prio #(.N(ENTRIES), .IDX_W(IDX_W)) u_prio (
    .match (match_vec),
    .found (win_found),
    .idx   (win_idx),
    .multi (win_multi)
  );

  logic [DATA_W-1:0]  win_lo;
  logic [PITCH_W-1:0] win_field;
  logic [PO_W-1:0]    win_pitch;

  assign win_lo    = lo_all[win_idx];
  assign win_field = win_lo[PITCH_LSB +: PITCH_W];
  assign win_pitch = PO_W'({1'b0, win_field} + (PITCH_W+1)'(1)) << UNIT_SHIFT;

  always_ff @(posedge clk) begin
    if (rst) begin
      lk_hit     <= 1'b0;
      lk_index   <= '0;
      lk_ytile   <= 1'b0;
      lk_pitch   <= '0;
      lk_overlap <= 1'b0;
    end else if (lk_req && win_found) begin
      lk_hit     <= 1'b1;
      lk_index   <= win_idx;
      lk_ytile   <= word_ytile(win_lo);
      lk_pitch   <= win_pitch;
      lk_overlap <= win_multi;
    end else begin
      lk_hit     <= 1'b0;
      lk_index   <= '0;
      lk_ytile   <= 1'b0;
      lk_pitch   <= '0;
      lk_overlap <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rd_data <= '0;
    end else if (reg_rd_en) begin
      reg_rd_data <= reg_rd_addr[0] ? hi_all[reg_rd_addr[IDX_W:1]]
                                    : lo_all[reg_rd_addr[IDX_W:1]];
    end
  end

  AST_OVERLAP_NEEDS_HIT: assert property (@(posedge clk) disable iff (rst)
    lk_overlap |-> lk_hit); // R8
  AST_HIT_NEEDS_REQ: assert property (@(posedge clk) disable iff (rst)
    lk_hit |-> $past(lk_req)); // R6
  AST_PITCH_UNITS: assert property (@(posedge clk) disable iff (rst)
    lk_hit |-> (lk_pitch[UNIT_SHIFT-1:0] == '0 && lk_pitch != '0)); // R7
  AST_WINNER_COVERED: assert property (@(posedge clk) disable iff (rst)
    lk_hit |-> ((($past(match_vec)) >> lk_index) & ENTRIES'(1)) != '0); // R8
  AST_MISS_IS_QUIET: assert property (@(posedge clk) disable iff (rst)
    !lk_hit |-> (lk_pitch == '0 && !lk_ytile && lk_index == '0)); // R9
endmodule

// File: tb/test_fence_bank.sv
module test_fence_bank;
  localparam int ENTRIES = 32;
  localparam int PITCH_W = 10;
  localparam int IDX_W   = $clog2(ENTRIES);
  localparam int NV      = 12;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic reg_wr_en = 1'b0;
  logic [IDX_W:0] reg_wr_addr = '0;
  logic [31:0] reg_wr_data = '0;
  logic reg_rd_en = 1'b0;
  logic [IDX_W:0] reg_rd_addr = '0;
  logic [31:0] reg_rd_data;
  logic lk_req = 1'b0;
  logic [31:0] lk_addr = '0;
  logic lk_hit, lk_ytile, lk_overlap;
  logic [IDX_W-1:0] lk_index;
  logic [PITCH_W+7:0] lk_pitch;

  always #5 clk = ~clk;

  fence_bank #(.ENTRIES(ENTRIES), .PITCH_W(PITCH_W)) i_fence_bank (
    .clk(clk), .rst(rst),
    .reg_wr_en(reg_wr_en), .reg_wr_addr(reg_wr_addr), .reg_wr_data(reg_wr_data),
    .reg_rd_en(reg_rd_en), .reg_rd_addr(reg_rd_addr), .reg_rd_data(reg_rd_data),
    .lk_req(lk_req), .lk_addr(lk_addr),
    .lk_hit(lk_hit), .lk_index(lk_index), .lk_ytile(lk_ytile),
    .lk_pitch(lk_pitch), .lk_overlap(lk_overlap)
  );

  // Lookup vectors: address, hit, index, ytile, pitch, overlap
  localparam logic [31:0] V_ADDR [NV] = '{
    32'h0000_FFFF, 32'h0001_0000, 32'h0001_1FFC, 32'h0001_2000,
    32'h0001_3FFF, 32'h0001_4000, 32'h0001_5FFF, 32'h0001_6000,
    32'h8000_0000, 32'h8000_0FFF, 32'h8000_1000, 32'h0000_0000};
  localparam logic V_HIT [NV] = '{0,1,1,1, 1,1,1,0, 1,1,0,0};
  localparam int   V_IDX [NV] = '{0,2,2,2, 2,5,5,0, 31,31,0,0};
  localparam logic V_Y   [NV] = '{0,0,0,0, 0,1,1,0, 1,1,0,0};
  localparam int   V_PIT [NV] = '{0,512,512,512, 512,128,128,0, 131072,131072,0,0};
  localparam logic V_OV  [NV] = '{0,0,0,1, 1,0,0,0, 0,0,0,0};

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input int idx, input bit half, input logic [31:0] d);
    @(negedge clk);
    reg_wr_en = 1'b1; reg_wr_addr = {IDX_W'(idx), half}; reg_wr_data = d;
    @(negedge clk);
    reg_wr_en = 1'b0;
  endtask

  task automatic rd(input int idx, input bit half, output logic [31:0] d);
    @(negedge clk);
    reg_rd_en = 1'b1; reg_rd_addr = {IDX_W'(idx), half};
    @(negedge clk);
    reg_rd_en = 1'b0;
    d = reg_rd_data;
  endtask

  function automatic logic [63:0] pack(input logic h, input int i, input logic y,
                                       input int p, input logic o);
    return {38'd0, h, IDX_W'(i), y, 18'(p), o};
  endfunction

  task automatic look(input logic [31:0] a, input logic req, output logic [63:0] r);
    @(negedge clk);
    lk_req = req; lk_addr = a;
    @(negedge clk);
    lk_req = 1'b0;
    r = pack(lk_hit, int'(lk_index), lk_ytile, int'(lk_pitch), lk_overlap);
  endtask

  task automatic program_ranges();
    wr(2, 0, 32'h0);          wr(2, 1, 32'h0001_3000); wr(2, 0, 32'h0001_000D);
    wr(5, 0, 32'h0);          wr(5, 1, 32'h0001_5000); wr(5, 0, 32'h0001_2003);
    wr(31, 0, 32'h0);         wr(31, 1, 32'h8000_0000); wr(31, 0, 32'h8000_0FFF);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    logic [63:0] r;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1: reset state
    rd(7, 0, d);  chk("R1 reset low word", d, 0);
    rd(7, 1, d);  chk("R1 reset high word", d, 0);
    // R10: all-zero entries cover page 0 but stay unarmed
    look(32'h0000_0010, 1, r); chk("R10 zero entry no match", r, 0);

    program_ranges();

    // R2 R3 R4 R11: readback layout
    rd(2, 0, d);  chk("R3 low word readback", d, 32'h0001_000D);
    wr(9, 1, 32'h0001_3ABC);
    rd(9, 1, d);  chk("R4 high word low bits dropped", d, 32'h0001_3000);
    rd(31, 0, d); chk("R11 top entry readback", d, 32'h8000_0FFF);
    rd(5, 1, d);  chk("R2 half select high", d, 32'h0001_5000);

    // R6 R7 R8 R9 R10 R11: vector table
    for (int k = 0; k < NV; k++) begin
      look(V_ADDR[k], 1, r);
      chk("R6/R7/R8 lookup vector", r, pack(V_HIT[k], V_IDX[k], V_Y[k], V_PIT[k], V_OV[k]));
    end

    // R9: no request gives quiet outputs
    look(32'h0001_0000, 0, r); chk("R9 no request", r, 0);

    // R5: high-word write disarms until the low word is rewritten
    wr(2, 1, 32'h0001_3000);
    look(32'h0001_0000, 1, r); chk("R5 disarmed after high write", r, 0);
    rd(2, 0, d);  chk("R5 armed bit cleared", d, 32'h0001_000C);
    look(32'h0001_2000, 1, r);
    chk("R8 single cover no overlap", r, pack(1, 5, 1, 128, 0));
    wr(2, 0, 32'h0001_000D);
    look(32'h0001_0000, 1, r); chk("R5 rearmed", r, pack(1, 2, 0, 512, 0));

    // R10: range kept but armed bit clear
    wr(31, 0, 32'h8000_0FFE);
    look(32'h8000_0100, 1, r); chk("R10 unarmed entry", r, 0);

    // R1: reset after programming
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    rd(2, 0, d);  chk("R1 cleared after reset", d, 0);
    look(32'h0001_0000, 1, r); chk("R1 no hit after reset", r, 0);

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule